// File: doc/BRIEF.md
# Pad Interrupt Router with Trigger Filter

This block watches a 256-wide bus of pad inputs and steers any eight of them onto eight interrupt lines. Each output channel has a byte-wide source select. The selected pad passes through a two-flop synchroniser and then a programmable glitch filter. After that comes a trigger stage. In level mode the stage passes the filtered signal through, inverted when the channel is set active-low. In edge mode it emits a one-cycle pulse on the rising edge, or on the falling edge when the channel is set active-low.

Software programs the block through a plain register port. Word-address strobes write data, and the read data appears combinationally while the read strobe is high. There are four 32-bit registers: trigger settings, two pad-select registers and the filter settings. Each register returns exactly what was last written, so a driver can update one channel with a read-modify-write of the whole word. Only the first `NUM_MAPPED` pad indices are wired. A select at or above that count routes the channel's inactive level.

When a write changes a channel's source or trigger fields, that channel's pipeline is flushed, so the change does not raise a false edge. Writes that leave a channel's fields unchanged do not disturb it.

Top module: `pad_irq_router`

## Requirements
- R1: After reset all four registers read zero and every interrupt output is low.
- R2: Word addresses 0 (trigger), 1 (select, channels 0-3), 2 (select, channels 4-7) and 3 (filter) each read back exactly the 32-bit value last written, including bits that have no function.
- R3: Word addresses 4 and above read as zero, and writes to them change no register.
- R4: Channel n takes its pad index from bits [8*(n mod 4)+7 : 8*(n mod 4)] of word 1 (n < 4) or word 2 (n >= 4), and follows that pad.
- R5: A pad index at or above NUM_MAPPED routes the inactive level, so the channel's output stays low whatever the pads do.
- R6: With word 0 bit n clear (level mode) and filter 0, output n equals the selected pad, inverted when word 0 bit 16+n is set. A pad change is visible after the third rising clock edge that samples it.
- R7: With word 0 bit n set (edge mode), output n is high for exactly one cycle on a rising edge of the pad (bit 16+n clear) or a falling edge (bit 16+n set), and never on the opposite edge.
- R8: With word 3 bits [4n+3:4n] = F > 0, a new pad level held for fewer than 4*F clock cycles is ignored. A level held for 4*F cycles is passed on, and it appears after the (4*F+2)-th rising edge that samples it.
- R9: A write that changes channel n's select, edge bit or polarity bit causes no output pulse on that channel, even when the old and new sources differ in level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when rd_i is low |
| pads_i | input | 256 | Pad inputs, asynchronous to clk_i |
| irq_o | output | 8 | Interrupt outputs, one per channel |

## Verification
The hardest situation to reach is a reconfiguration in which the old and new sources of an edge-mode channel sit at opposite levels. That is the only case where a false pulse could come out of the synchroniser and filter history. The bench parks the channel on a low pad with a high pad alongside it, then rewrites the select and watches the output for several cycles. It also flips the polarity while the source is high. The filter thresholds are exercised with glitches exactly one cycle shorter than the hold time, followed by levels held exactly long enough, for several filter values.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int NUM_CH    = 8;
  localparam int PAD_SPACE = 256;
  localparam int SEL_W     = 8;
  localparam int FILT_W    = 4;
  localparam int DATA_W    = 32;
  localparam int NUM_REGS  = 4;
  localparam int POL_BASE  = 16;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int CH_PER_SEL = DATA_W / SEL_W;

  typedef enum logic [IDX_W-1:0] {
    REG_TRIG   = 2'd0,
    REG_SEL_LO = 2'd1,
    REG_SEL_HI = 2'd2,
    REG_FILT   = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic              edge_trig;
    logic              pol_low;
    logic [SEL_W-1:0]  sel;
    logic [FILT_W-1:0] filt;
  } chan_cfg_t;
endpackage

// File: rtl/pir_regfile.sv
module pir_regfile
  import pir_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic                          rd_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output chan_cfg_t [NUM_CH-1:0]        cfg_o,
  output logic [NUM_CH-1:0]             chg_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              in_range;
  reg_idx_e          idx;

  assign in_range = addr_i < ADDR_W'(NUM_REGS);
  assign idx      = reg_idx_e'(addr_i[IDX_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= '0;
    end else if (wr_i && in_range) begin
      regs_q[idx] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i && in_range) rdata_o = regs_q[idx];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int SEL_REG = int'(REG_SEL_LO) + c / CH_PER_SEL;
    localparam int SEL_LSB = SEL_W * (c % CH_PER_SEL);
    logic trig_hit, sel_hit;

    assign cfg_o[c].edge_trig = regs_q[REG_TRIG][c];
    assign cfg_o[c].pol_low   = regs_q[REG_TRIG][POL_BASE+c];
    assign cfg_o[c].sel       = regs_q[SEL_REG][SEL_LSB +: SEL_W];
    assign cfg_o[c].filt      = regs_q[REG_FILT][FILT_W*c +: FILT_W];

    assign trig_hit = wr_i && in_range && (idx == REG_TRIG);
    assign sel_hit  = wr_i && in_range && (int'(idx) == SEL_REG);

    // only a real change of routing or trigger flushes the channel
    assign chg_o[c] =
        (trig_hit && ((wdata_i[c] != regs_q[REG_TRIG][c]) ||
                      (wdata_i[POL_BASE+c] != regs_q[REG_TRIG][POL_BASE+c]))) ||
        (sel_hit && (wdata_i[SEL_LSB +: SEL_W] != regs_q[SEL_REG][SEL_LSB +: SEL_W]));
  end
endmodule

// File: rtl/pir_filter.sv
module pir_filter #(
  parameter int FILT_W     = 4,
  parameter int FILT_SCALE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              din_i,
  input  logic [FILT_W-1:0] thr_sel_i,
  input  logic              load_i,
  output logic              dout_o
);
  localparam int CNT_W = FILT_W + $clog2(FILT_SCALE) + 1;

  logic [CNT_W-1:0] cnt_q, thr, cnt_inc;

  assign thr     = CNT_W'(thr_sel_i) * CNT_W'(FILT_SCALE);
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i || (thr_sel_i == '0)) begin
      dout_o <= din_i;
      cnt_q  <= '0;
    end else if (din_i == dout_o) begin
      cnt_q  <= '0;
    end else if (cnt_inc >= thr) begin
      dout_o <= din_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_inc;
    end
  end
endmodule

// File: rtl/pir_channel.sv
module pir_channel
  import pir_pkg::*;
#(
  parameter int NUM_MAPPED  = 133,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_SCALE  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PAD_SPACE-1:0] pads_i,
  input  chan_cfg_t            cfg_i,
  input  logic                 chg_i,
  output logic                 irq_o
);
  localparam int FL_W = $clog2(SYNC_STAGES + 3);
  localparam logic [FL_W-1:0] FLUSH_LEN = FL_W'(SYNC_STAGES + 2);

  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FL_W-1:0]        flush_q;
  logic                   filt, prev_q, edge_hit;

  // unmapped index: feed the inactive level for the current polarity
  assign raw = (int'(cfg_i.sel) < NUM_MAPPED) ? pads_i[cfg_i.sel] : cfg_i.pol_low;

  if (SYNC_STAGES > 1) begin : g_sync_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end
  end else begin : g_sync_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= raw;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flush_q <= '0;
    else if (chg_i)           flush_q <= FLUSH_LEN;
    else if (flush_q != '0)   flush_q <= flush_q - FL_W'(1);
  end

  pir_filter #(
    .FILT_W     (FILT_W),
    .FILT_SCALE (FILT_SCALE)
  ) u_filter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .din_i     (sync_q[SYNC_STAGES-1]),
    .thr_sel_i (cfg_i.filt),
    .load_i    (flush_q != '0),
    .dout_o    (filt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= filt;
  end

  assign edge_hit = cfg_i.pol_low ? (prev_q & ~filt) : (filt & ~prev_q);
  assign irq_o    = cfg_i.edge_trig ? (edge_hit && (flush_q == '0)) : (filt ^ cfg_i.pol_low);
endmodule

// File: rtl/pad_irq_router.sv
module pad_irq_router
  import pir_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int NUM_MAPPED  = 133,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_SCALE  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [PAD_SPACE-1:0] pads_i,
  output logic [NUM_CH-1:0]    irq_o
);
  chan_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_CH-1:0]      cfg_chg;
  logic [NUM_CH-1:0]      edge_mode;

  pir_regfile #(
    .ADDR_W (ADDR_W)
  ) u_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .cfg_o   (cfg),
    .chg_o   (cfg_chg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign edge_mode[c] = cfg[c].edge_trig;
    pir_channel #(
      .NUM_MAPPED  (NUM_MAPPED),
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_SCALE  (FILT_SCALE)
    ) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pads_i (pads_i),
      .cfg_i  (cfg[c]),
      .chg_i  (cfg_chg[c]),
      .irq_o  (irq_o[c])
    );
  end
endmodule

// File: rtl/pir_checker.sv
module pir_checker
  import pir_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic [NUM_CH-1:0]    irq_o,
  input logic [NUM_CH-1:0]    edge_mode_i,
  input logic [NUM_CH-1:0]    cfg_chg_i
);
  assert_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_i) && ($past(addr_i) < ADDR_W'(NUM_REGS)) && rd_i && !wr_i &&
     (addr_i == $past(addr_i))) |-> (rdata_o == $past(wdata_i)));

  assert_unmapped_read_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i >= ADDR_W'(NUM_REGS))) |-> (rdata_o == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assert_edge_single_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i[c] && irq_o[c] && !cfg_chg_i[c]) |=> !irq_o[c]);

    assert_no_pulse_on_reconfig_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_chg_i[c] |=> !(edge_mode_i[c] && irq_o[c]));
  end
endmodule

bind pad_irq_router pir_checker #(.ADDR_W(ADDR_W)) u_pir_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .edge_mode_i (edge_mode),
  .cfg_chg_i   (cfg_chg)
);

// File: tb/pad_irq_router_bench.sv
module pad_irq_router_bench;
  localparam int CLK_P   = 10;
  localparam int ADDR_W  = 4;
  localparam int MAPPED  = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [3:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [255:0] pads = '0;
  logic [7:0]   irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] mreg [4];

  always #(CLK_P/2) clk = ~clk;

  pad_irq_router #(.ADDR_W(ADDR_W), .NUM_MAPPED(MAPPED)) u_pad_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pads_i(pads), .irq_o(irq));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    addr = 4'(a); wdata = d; wr = 1'b1;
    step(1);
    wr = 1'b0;
    if (a < 4) mreg[a] = d;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    addr = 4'(a); rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  function automatic logic [7:0] sel_of(input int c);
    return (c < 4) ? mreg[1][8*(c%4) +: 8] : mreg[2][8*(c%4) +: 8];
  endfunction

  // level mode, polarity high, filter 0 expectation for all channels
  function automatic logic [7:0] exp_level();
    logic [7:0] e;
    for (int c = 0; c < 8; c++) begin
      int s = int'(sel_of(c));
      e[c] = (s < MAPPED) ? pads[s] : 1'b0;
    end
    return e;
  endfunction

  task automatic set_sel(input int c, input int idx);
    logic [31:0] v;
    v = (c < 4) ? mreg[1] : mreg[2];
    v[8*(c%4) +: 8] = 8'(idx);
    reg_wr((c < 4) ? 1 : 2, v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 4; i++) mreg[i] = '0;
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_rd(a, d);
      check(d == 32'h0, "R1 reg reset", d, 32'h0);
    end
    check(irq == 8'h0, "R1 irq reset", {24'h0, irq}, 32'h0);

    // R2 readback of all bits
    for (int a = 0; a < 4; a++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] v = (32'h9E37_79B9 * (a * 4 + p + 1)) ^ (32'h1 << (a * 8 + p));
        reg_wr(a, v);
        reg_rd(a, d);
        check(d == v, "R2 readback", d, v);
      end
      reg_wr(a, 32'h0);
    end
    step(8);

    // R3 unmapped offsets
    reg_wr(1, 32'h0302_0100);
    reg_wr(2, 32'h0706_0504);
    for (int a = 4; a < 16; a++) begin
      reg_wr(a, 32'hFFFF_FFFF);
      reg_rd(a, d);
      check(d == 32'h0, "R3 unmapped read", d, 32'h0);
    end
    for (int a = 0; a < 4; a++) begin
      reg_rd(a, d);
      check(d == mreg[a], "R3 write ignored", d, mreg[a]);
    end
    step(8);

    // R4/R5 sweep over the whole select space
    for (int idx = 0; idx < 256; idx++) begin
      int c = idx % 8;
      set_sel(c, idx);
      step(6);
      pads = '0;
      step(4);
      check(irq == exp_level(), "R4 idle", {24'h0, irq}, {24'h0, exp_level()});
      pads = 256'h1 << idx;
      step(4);
      if (idx < MAPPED)
        check(irq == exp_level(), "R4 routed", {24'h0, irq}, {24'h0, exp_level()});
      else
        check(irq == exp_level(), "R5 unmapped inactive", {24'h0, irq}, {24'h0, exp_level()});
    end
    pads = '0;
    reg_wr(1, 32'h0302_0100);
    reg_wr(2, 32'h0706_0504);
    step(8);

    // R5 unmapped with active-low: still low output
    set_sel(6, 200);
    reg_wr(0, mreg[0] | (32'h1 << 22));
    step(8);
    for (int p = 0; p < 2; p++) begin
      pads = p ? '1 : '0;
      step(4);
      check(irq[6] == 1'b0, "R5 unmapped active-low", {31'h0, irq[6]}, 32'h0);
    end
    pads = '0;
    reg_wr(0, 32'h0);
    step(8);

    // R6 level polarity and latency, ch2 on pad 3
    set_sel(2, 3);
    for (int pol = 0; pol < 2; pol++) begin
      reg_wr(0, pol ? 32'h0004_0000 : 32'h0);
      step(8);
      pads[3] = 1'b1;
      step(2);
      check(irq[2] == 1'(pol), "R6 before latency", {31'h0, irq[2]}, 32'(pol));
      step(1);
      check(irq[2] == 1'(!pol), "R6 after latency", {31'h0, irq[2]}, 32'(!pol));
      pads[3] = 1'b0;
      step(4);
      check(irq[2] == 1'(pol), "R6 release", {31'h0, irq[2]}, 32'(pol));
    end
    reg_wr(0, 32'h0);
    step(8);

    // R7 edge mode, ch5 on pad 7
    set_sel(5, 7);
    for (int pol = 0; pol < 2; pol++) begin
      reg_wr(0, 32'h20 | (pol ? 32'h0020_0000 : 32'h0));
      step(8);
      // wrong edge first
      pads[7] = pol ? 1'b1 : 1'b0;
      for (int k = 0; k < 6; k++) begin
        step(1);
        check(irq[5] == 1'b0, "R7 opposite edge", {31'h0, irq[5]}, 32'h0);
      end
      pads[7] = pol ? 1'b0 : 1'b1;
      step(2);
      check(irq[5] == 1'b0, "R7 pre-pulse", {31'h0, irq[5]}, 32'h0);
      step(1);
      check(irq[5] == 1'b1, "R7 pulse", {31'h0, irq[5]}, 32'h1);
      step(1);
      check(irq[5] == 1'b0, "R7 pulse width", {31'h0, irq[5]}, 32'h0);
      if (pol == 0) begin
        pads[7] = 1'b0;
        for (int k = 0; k < 6; k++) begin
          step(1);
          check(irq[5] == 1'b0, "R7 falling ignored", {31'h0, irq[5]}, 32'h0);
        end
      end
    end
    pads = '0;
    reg_wr(0, 32'h0);
    step(8);

    // R8 filter, ch1 on pad 9
    set_sel(1, 9);
    for (int f = 1; f <= 3; f++) begin
      reg_wr(3, 32'(f) << 4);
      step(8);
      pads[9] = 1'b1;
      repeat (4 * f - 1) @(posedge clk);
      @(negedge clk);
      pads[9] = 1'b0;
      for (int k = 0; k < 4 * f + 4; k++) begin
        step(1);
        check(irq[1] == 1'b0, "R8 glitch rejected", {31'h0, irq[1]}, 32'h0);
      end
      pads[9] = 1'b1;
      step(4 * f + 1);
      check(irq[1] == 1'b0, "R8 before threshold", {31'h0, irq[1]}, 32'h0);
      step(1);
      check(irq[1] == 1'b1, "R8 held level passes", {31'h0, irq[1]}, 32'h1);
      pads[9] = 1'b0;
      step(4 * f + 4);
      check(irq[1] == 1'b0, "R8 release", {31'h0, irq[1]}, 32'h0);
    end
    reg_wr(3, 32'h0);
    step(8);

    // R9 reconfiguration without false pulse, ch5 edge rising
    set_sel(5, 7);
    reg_wr(0, 32'h20);
    pads[7] = 1'b0;
    pads[8] = 1'b1;
    step(8);
    set_sel(5, 8);
    for (int k = 0; k < 10; k++) begin
      check(irq[5] == 1'b0, "R9 select change", {31'h0, irq[5]}, 32'h0);
      step(1);
    end
    reg_wr(0, 32'h0020_0020);
    for (int k = 0; k < 10; k++) begin
      check(irq[5] == 1'b0, "R9 polarity change", {31'h0, irq[5]}, 32'h0);
      step(1);
    end
    reg_wr(0, 32'h0);
    step(8);
    reg_wr(0, 32'h20);
    for (int k = 0; k < 10; k++) begin
      check(irq[5] == 1'b0, "R9 mode change", {31'h0, irq[5]}, 32'h0);
      step(1);
    end
    pads[8] = 1'b0;
    step(4);
    pads[8] = 1'b1;
    step(3);
    check(irq[5] == 1'b1, "R9 live after reconfig", {31'h0, irq[5]}, 32'h1);

    step(4);
    finish_run();
  end
endmodule